// File: doc/BRIEF.md
# Per-Port Status LED Controller

This block drives the status lamps of one network port. It takes the port's raw status levels: line speed, transmit activity, receive activity, collision, link, duplex and isolate. These may come from other clock domains. A parallel configuration word picks a display mode for each of the lamps and a pulse-stretch interval. Each lamp gets one active-low drive output, suited to an open-drain pad: a low output means the lamp is lit.

All timing runs from one shared tick. The tick is divided down from the system clock and is nominally 1 ms. After reset releases, every lamp is held lit for a lamp test of `LAMP_TICKS` ticks, which is about one second at the default settings. After the test, each lamp follows its own mode.

The activity and collision events are stretched. A rising edge starts a retriggerable timer, so short bursts stay visible. A combined link/activity mode lights the lamp steadily while link is up. When traffic flows, the lamp blinks at the selected stretch interval. Status inputs pass through a two-flop synchronizer first, and each lamp output is registered.

Top module: `led_port_ctrl`

## Requirements
- R1: While `rst` is high, every bit of `led_n_o` is 1, so all lamps are dark.
- R2: After `rst` falls, all lamps are lit (`led_n_o` all 0) for `LAMP_TICKS` ticks. After that, each lamp follows its configured mode.
- R3: Level mode codes, where 1 on the status means lit:
  - 4'b0000 shows speed (1 = fast rate).
  - 4'b0100 shows link.
  - 4'b0101 shows duplex (1 = full).
  - 4'b0110 shows isolate.
- R4: Any mode code outside the set {0000, 0001, 0010, 0011, 0100, 0101, 0110, 1101} keeps the lamp dark, whatever the status inputs are.
- R5: Event mode codes are 4'b0001 transmit, 4'b0010 receive and 4'b0011 collision. With `stretch_en_i` high, a rising edge of the event lights the lamp until a timer of N ticks expires. `stretch_sel_i` sets N:
  - 2'b00 gives `ST_SHORT`.
  - 2'b01 gives `ST_MID`.
  - 2'b10 gives `ST_LONG`.
  - 2'b11 is reserved and behaves as 2'b00.
- R6: A new rising edge that arrives before the timer expires reloads the timer to the full N ticks, which lengthens the lit time.
- R7: With `stretch_en_i` low, an event-mode lamp follows the synchronized event level directly, with no stretching.
- R8: In mode 4'b1101, the lamp is dark while link is down. It is steadily lit while link is up and no activity is present.
- R9: In mode 4'b1101, while link is up and activity is present, the lamp toggles every N ticks, with N taken from the stretch selection. Activity means transmit or receive, after stretching. The first toggle goes dark one interval after activity starts. The lamp returns to steady lit once activity ends.
- R10: A status input change reaches a level-mode lamp output on the third rising clock edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_i | input | 1 | Line speed status, 1 = fast rate |
| tx_act_i | input | 1 | Transmit activity level |
| rx_act_i | input | 1 | Receive activity level |
| col_i | input | 1 | Collision level |
| link_i | input | 1 | Link up level |
| duplex_i | input | 1 | Duplex status, 1 = full |
| isolate_i | input | 1 | Isolate status |
| led_mode_i | input | 4*NUM_LEDS | Mode code per lamp, lamp k at bits [4k+3:4k] |
| stretch_sel_i | input | 2 | Stretch interval select |
| stretch_en_i | input | 1 | 1 = stretch events, 0 = follow raw event level |
| led_n_o | output | NUM_LEDS | Active-low lamp drive, 0 = lit |

## Verification
A fault in the stretch timer shows on an event-mode lamp within a single stretch interval. A load or decrement that is too short darkens the lamp before N-1 ticks have passed. A timer that fails to reload on a second edge darkens it before the extended window ends. A wrong blink counter or phase moves the dark and lit windows of the combined mode by at least one tick, and that shift shows within the first toggle period. Synchronizer or lamp-test counter errors show as an output change one cycle early or late, or as a lamp test that ends early or late by at least one tick.

// File: rtl/led_pkg.sv
package led_pkg;

    localparam int MODE_W   = 4;
    localparam int NUM_EV   = 3;
    localparam int EV_TX    = 0;
    localparam int EV_RX    = 1;
    localparam int EV_COL   = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_SPEED   = 4'b0000,
        MODE_TX      = 4'b0001,
        MODE_RX      = 4'b0010,
        MODE_COL     = 4'b0011,
        MODE_LINK    = 4'b0100,
        MODE_DUPLEX  = 4'b0101,
        MODE_ISOLATE = 4'b0110,
        MODE_LINKACT = 4'b1101
    } led_mode_e;

    typedef enum logic [1:0] {
        STR_SHORT = 2'b00,
        STR_MID   = 2'b01,
        STR_LONG  = 2'b10,
        STR_RSVD  = 2'b11
    } stretch_sel_e;

    typedef struct packed {
        logic speed;
        logic tx;
        logic rx;
        logic col;
        logic link;
        logic duplex;
        logic isolate;
    } port_status_t;

    localparam int STATUS_W = $bits(port_status_t);

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Reserved select falls back to the short interval.
    function automatic int stretch_ticks(logic [1:0] sel, int t_short, int t_mid, int t_long);
        case (stretch_sel_e'(sel))
            STR_MID:  return t_mid;
            STR_LONG: return t_long;
            default:  return t_short;
        endcase
    endfunction

    function automatic logic mode_known(logic [MODE_W-1:0] code);
        case (led_mode_e'(code))
            MODE_SPEED, MODE_TX, MODE_RX, MODE_COL, MODE_LINK,
            MODE_DUPLEX, MODE_ISOLATE, MODE_LINKACT: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Lamp state (1 = lit) for one mode code.
    function automatic logic mode_lit(logic [MODE_W-1:0] code, port_status_t st,
                                      logic [NUM_EV-1:0] ev, logic blink_dark);
        case (led_mode_e'(code))
            MODE_SPEED:   return st.speed;
            MODE_TX:      return ev[EV_TX];
            MODE_RX:      return ev[EV_RX];
            MODE_COL:     return ev[EV_COL];
            MODE_LINK:    return st.link;
            MODE_DUPLEX:  return st.duplex;
            MODE_ISOLATE: return st.isolate;
            MODE_LINKACT: return st.link & ~blink_dark;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int CLKS_PER_TICK = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST) && !rst;
endmodule

// File: rtl/led_sync.sv
module led_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    logic [W-1:0] stable;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '0;
            stable <= '0;
        end else begin
            meta   <= d;
            stable <= meta;
        end
    end

    assign q = stable;
endmodule

// File: rtl/led_event_stretch.sv
module led_event_stretch #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ev,
    input  logic          stretch_en,
    input  logic [TW-1:0] load,
    output logic          ev_out
);
    logic          ev_q;
    logic [TW-1:0] remain;
    logic          rise;

    assign rise = ev & ~ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q   <= 1'b0;
            remain <= '0;
        end else begin
            ev_q <= ev;
            if (!stretch_en) begin
                remain <= '0;
            end else if (rise) begin
                remain <= load;
            end else if (tick && remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign ev_out = stretch_en ? (remain != '0) : ev;
endmodule

// File: rtl/led_blink.sv
module led_blink #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          active,
    input  logic [TW-1:0] period,
    output logic          dark
);
    logic [TW-1:0] phase_cnt;
    logic          dark_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase_cnt <= '0;
            dark_q    <= 1'b0;
        end else if (tick) begin
            if (phase_cnt + 1'b1 >= period) begin
                phase_cnt <= '0;
                dark_q    <= ~dark_q;
            end else begin
                phase_cnt <= phase_cnt + 1'b1;
            end
        end
    end

    assign dark = dark_q;
endmodule

// File: rtl/led_port_ctrl.sv
module led_port_ctrl
    import led_pkg::*;
#(
    parameter int NUM_LEDS      = 3,
    parameter int CLKS_PER_TICK = 100000,
    parameter int LAMP_TICKS    = 1000,
    parameter int ST_SHORT      = 30,
    parameter int ST_MID        = 60,
    parameter int ST_LONG       = 100
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       speed_i,
    input  logic                       tx_act_i,
    input  logic                       rx_act_i,
    input  logic                       col_i,
    input  logic                       link_i,
    input  logic                       duplex_i,
    input  logic                       isolate_i,
    input  logic [NUM_LEDS*MODE_W-1:0] led_mode_i,
    input  logic [1:0]                 stretch_sel_i,
    input  logic                       stretch_en_i,
    output logic [NUM_LEDS-1:0]        led_n_o
);
    localparam int ST_MAX = max3(ST_SHORT, ST_MID, ST_LONG);
    localparam int TW     = $clog2(ST_MAX + 1);
    localparam int LW     = $clog2(LAMP_TICKS + 1);
    localparam logic [LW-1:0] LAMP_LAST = LW'(LAMP_TICKS);

    logic                tick;
    port_status_t        st_raw;
    port_status_t        st_s;
    logic [STATUS_W-1:0] st_sync_vec;
    logic [NUM_EV-1:0]   ev_sync;
    logic [NUM_EV-1:0]   ev_str;
    logic [TW-1:0]       str_load;
    logic                activity;
    logic                blink_dark;
    logic [LW-1:0]       lamp_cnt;
    logic                lamp_active;
    logic [NUM_LEDS-1:0] led_on;
    logic [NUM_LEDS-1:0] led_n_q;

    led_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    always_comb begin
        st_raw.speed   = speed_i;
        st_raw.tx      = tx_act_i;
        st_raw.rx      = rx_act_i;
        st_raw.col     = col_i;
        st_raw.link    = link_i;
        st_raw.duplex  = duplex_i;
        st_raw.isolate = isolate_i;
    end

    led_sync #(.W(STATUS_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (st_raw),
        .q   (st_sync_vec)
    );

    assign st_s = port_status_t'(st_sync_vec);

    assign ev_sync[EV_TX]  = st_s.tx;
    assign ev_sync[EV_RX]  = st_s.rx;
    assign ev_sync[EV_COL] = st_s.col;

    assign str_load = TW'(stretch_ticks(stretch_sel_i, ST_SHORT, ST_MID, ST_LONG));

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        led_event_stretch #(.TW(TW)) u_stretch (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .ev         (ev_sync[e]),
            .stretch_en (stretch_en_i),
            .load       (str_load),
            .ev_out     (ev_str[e])
        );
    end

    assign activity = ev_str[EV_TX] | ev_str[EV_RX];

    led_blink #(.TW(TW)) u_blink (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .active (activity & st_s.link),
        .period (str_load),
        .dark   (blink_dark)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_cnt <= '0;
        end else if (tick && lamp_active) begin
            lamp_cnt <= lamp_cnt + 1'b1;
        end
    end

    assign lamp_active = (lamp_cnt != LAMP_LAST);

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
        assign led_on[g] = mode_lit(led_mode_i[g*MODE_W +: MODE_W], st_s, ev_str, blink_dark);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_n_q <= '1;
        end else if (lamp_active) begin
            led_n_q <= '0;
        end else begin
            led_n_q <= ~led_on;
        end
    end

    assign led_n_o = led_n_q;
endmodule

// File: rtl/led_port_chk.sv
module led_port_chk
    import led_pkg::*;
#(
    parameter int NUM_LEDS      = 3,
    parameter int CLKS_PER_TICK = 100000
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tick,
    input logic                       lamp_active,
    input logic [NUM_LEDS*MODE_W-1:0] led_mode_i,
    input logic                       stretch_en_i,
    input port_status_t               st_s,
    input logic [NUM_EV-1:0]          ev_sync,
    input logic [NUM_EV-1:0]          ev_str,
    input logic [NUM_LEDS-1:0]        led_n_o
);
    // R2
    lamp_lit_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_active |=> (led_n_o == '0));

    // R5
    tx_edge_lights_chk: assert property (@(posedge clk) disable iff (rst)
        (stretch_en_i && ev_sync[EV_TX] && !$past(ev_sync[EV_TX]))
            |=> (ev_str[EV_TX] || !stretch_en_i));

    if (CLKS_PER_TICK > 1) begin : g_tick_chk
        // R5
        tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
    end

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led_chk
        // R3
        speed_follow_chk: assert property (@(posedge clk) disable iff (rst)
            (!lamp_active && led_mode_i[g*MODE_W +: MODE_W] == MODE_SPEED)
                |=> (led_n_o[g] == !$past(st_s.speed)));

        // R4
        undef_dark_chk: assert property (@(posedge clk) disable iff (rst)
            (!lamp_active && !mode_known(led_mode_i[g*MODE_W +: MODE_W]))
                |=> led_n_o[g]);

        // R8
        linkact_down_chk: assert property (@(posedge clk) disable iff (rst)
            (!lamp_active && led_mode_i[g*MODE_W +: MODE_W] == MODE_LINKACT && !st_s.link)
                |=> led_n_o[g]);
    end
endmodule

bind led_port_ctrl led_port_chk #(
    .NUM_LEDS      (NUM_LEDS),
    .CLKS_PER_TICK (CLKS_PER_TICK)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .lamp_active  (lamp_active),
    .led_mode_i   (led_mode_i),
    .stretch_en_i (stretch_en_i),
    .st_s         (st_s),
    .ev_sync      (ev_sync),
    .ev_str       (ev_str),
    .led_n_o      (led_n_o)
);

// File: tb/tb_led_port_ctrl.sv
module tb_led_port_ctrl;
    localparam int NL   = 3;
    localparam int CPT  = 4;
    localparam int LAMP = 10;
    localparam int TS   = 3;
    localparam int TM   = 6;
    localparam int TL   = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          speed = 0, tx = 0, rx = 0, col = 0, link = 0, duplex = 0, isolate = 0;
    logic [3:0]    mode0 = 4'h1, mode1 = 4'hD, mode2 = 4'hF;
    logic [1:0]    ssel = 2'b00;
    logic          sen = 1'b1;
    logic [NL-1:0] led_n;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int          at;
        logic [2:0]  exp;
        logic [2:0]  mask;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    led_port_ctrl #(
        .NUM_LEDS(NL), .CLKS_PER_TICK(CPT), .LAMP_TICKS(LAMP),
        .ST_SHORT(TS), .ST_MID(TM), .ST_LONG(TL)
    ) dut (
        .clk(clk), .rst(rst), .speed_i(speed), .tx_act_i(tx), .rx_act_i(rx),
        .col_i(col), .link_i(link), .duplex_i(duplex), .isolate_i(isolate),
        .led_mode_i({mode2, mode1, mode0}), .stretch_sel_i(ssel),
        .stretch_en_i(sen), .led_n_o(led_n)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Scoreboard driver side: expected lit pattern d cycles from now.
    task automatic expect_lit(int d, logic [2:0] exp, logic [2:0] mask, string tag);
        exp_t it;
        it.at = cyc + d; it.exp = exp; it.mask = mask; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare lit pattern against queued expectations.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            if (it.at == cyc) begin
                logic [2:0] lit;
                lit = ~led_n;
                n_cmp++;
                if ((lit & it.mask) != (it.exp & it.mask)) begin
                    n_bad++;
                    $display("FAIL %s at cycle %0d: lit=%b expected=%b (mask %b)",
                             it.tag, cyc, lit & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    task automatic pulse(int which);
        if (which == 0) tx = 1; else if (which == 1) rx = 1; else col = 1;
        step(2);
        tx = 0; rx = 0; col = 0;
    endtask

    // Stretch window for N ticks at CPT clocks per tick, pulse applied now.
    task automatic stretch_case(int which, int n, logic [2:0] mask, string tag);
        expect_lit(6, mask, mask, tag);
        expect_lit(4*n - 2, mask, mask, tag);
        expect_lit(4*n + 6, 3'b000, mask, tag);
        pulse(which);
        step(4*n + 10);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        #1;
        // R1: dark during reset
        step(2);
        expect_lit(1, 3'b000, 3'b111, "R1");
        step(4);
        rst = 0;
        // R2: lamp test, then modes (tx idle, link down, undefined code)
        expect_lit(20, 3'b111, 3'b111, "R2");
        expect_lit(60, 3'b000, 3'b111, "R2");
        step(62);

        // R3 / R10: speed level on lamp 2
        mode2 = 4'b0000; speed = 1;
        expect_lit(1, 3'b000, 3'b100, "R10");
        expect_lit(2, 3'b000, 3'b100, "R10");
        expect_lit(3, 3'b100, 3'b100, "R10");
        step(6);
        speed = 0;
        expect_lit(4, 3'b000, 3'b100, "R3");
        step(6);
        mode2 = 4'b0101; duplex = 1;
        expect_lit(4, 3'b100, 3'b100, "R3");
        step(6);
        duplex = 0; mode2 = 4'b0110; isolate = 1;
        expect_lit(4, 3'b100, 3'b100, "R3");
        step(6);
        isolate = 0; mode2 = 4'b0100; link = 1;
        expect_lit(4, 3'b100, 3'b100, "R3");
        step(6);
        // R4: undefined codes stay dark with every status high
        speed = 1; duplex = 1; isolate = 1; sen = 0; tx = 1; rx = 1; col = 1;
        mode2 = 4'b0111;
        expect_lit(5, 3'b000, 3'b100, "R4");
        step(8);
        mode2 = 4'b1110;
        expect_lit(3, 3'b000, 3'b100, "R4");
        step(6);
        speed = 0; duplex = 0; isolate = 0; link = 0; tx = 0; rx = 0; col = 0; sen = 1;
        step(12);

        // R5: each stretch selection on transmit (lamp 0)
        ssel = 2'b00; step(2); stretch_case(0, TS, 3'b001, "R5");
        ssel = 2'b01; step(2); stretch_case(0, TM, 3'b001, "R5");
        ssel = 2'b10; step(2); stretch_case(0, TL, 3'b001, "R5");
        ssel = 2'b11; step(2); stretch_case(0, TS, 3'b001, "R5");
        ssel = 2'b00;
        // R5: receive and collision on lamp 2
        mode2 = 4'b0010; step(2); stretch_case(1, TS, 3'b100, "R5");
        mode2 = 4'b0011; step(2); stretch_case(2, TS, 3'b100, "R5");
        mode2 = 4'hF;

        // R6: retrigger extends lit time
        step(2);
        expect_lit(18, 3'b001, 3'b001, "R6");
        expect_lit(28, 3'b000, 3'b001, "R6");
        pulse(0);
        step(6);
        pulse(0);
        step(30);

        // R7: stretching disabled follows raw level
        sen = 0;
        step(2);
        tx = 1;
        expect_lit(10, 3'b001, 3'b001, "R7");
        expect_lit(19, 3'b001, 3'b001, "R7");
        expect_lit(25, 3'b000, 3'b001, "R7");
        step(20);
        tx = 0;
        step(10);
        expect_lit(4, 3'b001, 3'b001, "R7");
        expect_lit(8, 3'b000, 3'b001, "R7");
        pulse(0);
        step(10);

        // R8: combined mode, link down then up and idle (lamp 1)
        expect_lit(2, 3'b000, 3'b010, "R8");
        step(4);
        link = 1;
        expect_lit(4, 3'b010, 3'b010, "R8");
        step(6);
        // R9: blink while activity continues
        tx = 1;
        expect_lit(6,  3'b010, 3'b010, "R9");
        expect_lit(19, 3'b000, 3'b010, "R9");
        expect_lit(31, 3'b010, 3'b010, "R9");
        expect_lit(43, 3'b000, 3'b010, "R9");
        step(45);
        tx = 0;
        expect_lit(7, 3'b010, 3'b010, "R9");
        step(10);
        link = 0;
        expect_lit(4, 3'b000, 3'b010, "R8");
        step(8);

        finish_run();
    end
endmodule